// File: doc/BRIEF.md
# Low-Power Bus Status Encoder

This block drives the 8-bit PHY-to-link data bus of a ULPI-style interface while the PHY sits in its low-power (suspend) state. During that state every PHY clock may be stopped, so the bus carries only values that need no clock. Two bits carry the full-speed line state straight from the receivers. One bit is an interrupt flag. The remaining bits are held low.

The flag watches four comparator levels: VBUS valid, session valid, session end and ID ground. Each level has its own rising-edge enable and its own falling-edge enable. A transition in an enabled direction is caught by an edge-clocked latch, so it is seen without any clock. When the block enters low power, it takes a snapshot of the levels as a baseline on the first clock edge. When it leaves low power, it issues a one-cycle clear pulse that empties the latches. A quiet mask can silence the VBUS-valid and session-end sources to save suspend current.

Top module: `ulpi_lp_status_enc`

## Requirements
- R1: While `lp_mode` is 1, `data_oe` is 1. While `lp_mode` is 0, `data_oe` is 0 and `data_out` is all zero.
- R2: In low power, `data_out[0]` equals `line_st[0]` and `data_out[1]` equals `line_st[1]`, combinationally and with no register in the path.
- R3: In low power, `data_out[2]` and `data_out[7:4]` are 0.
- R4: In low power, `data_out[3]` is 1 when at least one armed source has an enabled edge captured or pending. The source bits of `comp_lvl` are: bit 0 VBUS valid, bit 1 session valid, bit 2 session end, bit 3 ID ground.
- R5: A 0-to-1 change on source i counts only when `rise_en[i]` is set. A 1-to-0 change counts only when `fall_en[i]` is set.
- R6: While `quiet_mask` is 1, changes on bits 0 and 2 never raise the flag. Bits 1 and 3 are not affected.
- R7: An edge is captured asynchronously and held even if the level returns to its earlier value. This works while the clock is stopped.
- R8: The sources are armed from the first clock edge that sees `lp_mode` at 1. That edge records `comp_lvl` as the baseline, so entering low power raises no flag. A level that differs from the baseline in an enabled direction also shows on the flag.
- R9: `irq_clr` pulses for exactly one cycle, starting at the first clock edge that sees `lp_mode` at 0 after low power. That pulse empties all edge latches.
- R10: A synchronous reset disarms all sources, clears the baseline and clears `irq_clr`. Reset also empties the edge latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock; may stop during low power |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 1 | Low-power state flag |
| line_st | input | 2 | Full-speed receiver line state |
| comp_lvl | input | 4 | Comparator levels: VBUS valid, session valid, session end, ID ground |
| rise_en | input | 4 | Per-source rising-edge enables |
| fall_en | input | 4 | Per-source falling-edge enables |
| quiet_mask | input | 1 | Silences the VBUS-valid and session-end sources |
| data_out | output | 8 | Data bus value in the low-power mapping |
| data_oe | output | 1 | Data bus drive enable |
| irq_clr | output | 1 | One-cycle clear for the edge latches on low-power exit |

## Verification
The assertions assume that `lp_mode` does not rise again in the cycle that carries the clear pulse. They also assume that the comparator levels never change exactly on a clock edge. The stimulus always leaves low power for several cycles before re-entering it. It moves `comp_lvl` one time unit after a falling clock edge, or while the clock is halted. The reference model in the bench tracks the edges on its own and is compared with the outputs on every falling clock edge. During the halted-clock window, the bench calls the same comparison by hand.

// File: rtl/ulpi_lp_pkg.sv
package ulpi_lp_pkg;

    localparam int NSRC     = 4;
    localparam int BUS_W    = 8;
    localparam int LINE_W   = 2;

    typedef enum int {
        SRC_VBUS_OK  = 0,
        SRC_SESS_OK  = 1,
        SRC_SESS_LOW = 2,
        SRC_ID_GND   = 3
    } src_idx_e;

    // sources that the quiet mask may silence
    localparam logic [NSRC-1:0] QUIET_SET = (NSRC'(1) << SRC_VBUS_OK) | (NSRC'(1) << SRC_SESS_LOW);

    typedef struct packed {
        logic [3:0]        zero_hi;
        logic              flag;
        logic              zero_lo;
        logic [LINE_W-1:0] line;
    } lp_bus_t;

    function automatic lp_bus_t lp_pack(input logic [LINE_W-1:0] line, input logic flag);
        lp_bus_t b;
        b.zero_hi = '0;
        b.flag    = flag;
        b.zero_lo = 1'b0;
        b.line    = line;
        return b;
    endfunction

endpackage

// File: rtl/ulpi_lp_ctrl.sv
module ulpi_lp_ctrl
    import ulpi_lp_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lp_mode,
    input  logic [N-1:0] comp_lvl,
    output logic         armed,
    output logic [N-1:0] base,
    output logic         clr_pulse
);

    logic lp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q      <= 1'b0;
            base      <= '0;
            clr_pulse <= 1'b0;
        end else begin
            lp_q      <= lp_mode;
            clr_pulse <= lp_q & ~lp_mode;
            if (lp_mode && !lp_q) begin
                base <= comp_lvl;
            end
        end
    end

    assign armed = lp_q;

    a_r8_base_hold: assert property (@(posedge clk) disable iff (rst)
        (lp_q && lp_mode) |=> $stable(base));

    a_r9_clr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !clr_pulse);

    a_r9_clr_follows_exit: assert property (@(posedge clk) disable iff (rst)
        (lp_q && !lp_mode) |=> clr_pulse);

endmodule

// File: rtl/ulpi_lp_edge_cap.sv
module ulpi_lp_edge_cap (
    input  logic src,
    input  logic base,
    input  logic arm,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic latched,
    output logic hit
);

    logic rise_q;
    logic fall_q;
    logic pending;

    always_ff @(posedge src or posedge clr) begin
        if (clr) begin
            rise_q <= 1'b0;
        end else if (arm && rise_en) begin
            rise_q <= 1'b1;
        end
    end

    always_ff @(negedge src or posedge clr) begin
        if (clr) begin
            fall_q <= 1'b0;
        end else if (arm && fall_en) begin
            fall_q <= 1'b1;
        end
    end

    // level already away from the baseline in an enabled direction
    assign pending = arm & ((src & ~base & rise_en) | (~src & base & fall_en));
    assign latched = rise_q | fall_q;
    assign hit     = latched | pending;

endmodule

// File: rtl/ulpi_lp_status_enc.sv
module ulpi_lp_status_enc
    import ulpi_lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_mode,
    input  logic [LINE_W-1:0] line_st,
    input  logic [NSRC-1:0]   comp_lvl,
    input  logic [NSRC-1:0]   rise_en,
    input  logic [NSRC-1:0]   fall_en,
    input  logic              quiet_mask,
    output logic [BUS_W-1:0]  data_out,
    output logic              data_oe,
    output logic              irq_clr
);

    logic            armed;
    logic [NSRC-1:0] base;
    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] latched;
    logic            cap_clr;
    lp_bus_t         bus;

    ulpi_lp_ctrl #(.N(NSRC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .lp_mode   (lp_mode),
        .comp_lvl  (comp_lvl),
        .armed     (armed),
        .base      (base),
        .clr_pulse (irq_clr)
    );

    assign cap_clr = irq_clr | rst;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic src_arm;
        assign src_arm = armed & ~(quiet_mask & QUIET_SET[i]);
        ulpi_lp_edge_cap u_cap (
            .src     (comp_lvl[i]),
            .base    (base[i]),
            .arm     (src_arm),
            .rise_en (rise_en[i]),
            .fall_en (fall_en[i]),
            .clr     (cap_clr),
            .latched (latched[i]),
            .hit     (hit[i])
        );
    end

    assign bus      = lp_pack(line_st, |hit);
    assign data_out = lp_mode ? BUS_W'(bus) : '0;
    assign data_oe  = lp_mode;

    a_r9_clr_empties: assert property (@(posedge clk) disable iff (rst)
        irq_clr |-> (latched == '0));

    a_r1_release_clears: assert property (@(posedge clk) disable iff (rst)
        irq_clr |-> !data_oe || !lp_mode);

endmodule

// File: tb/test_ulpi_lp_status_enc.sv
`timescale 1ns/1ps
module test_ulpi_lp_status_enc;

    logic       clk = 1'b0;
    logic       run = 1'b1;
    logic       rst = 1'b1;
    logic       lp_mode = 1'b0;
    logic [1:0] line_st = 2'b00;
    logic [3:0] comp_lvl = 4'b0000;
    logic [3:0] rise_en = 4'b0000;
    logic [3:0] fall_en = 4'b0000;
    logic       quiet_mask = 1'b0;
    logic [7:0] data_out;
    logic       data_oe;
    logic       irq_clr;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit done = 0;

    ulpi_lp_status_enc i_ulpi_lp_status_enc (
        .clk(clk), .rst(rst), .lp_mode(lp_mode), .line_st(line_st),
        .comp_lvl(comp_lvl), .rise_en(rise_en), .fall_en(fall_en),
        .quiet_mask(quiet_mask), .data_out(data_out), .data_oe(data_oe),
        .irq_clr(irq_clr)
    );

    always #2.5 if (run) clk = ~clk;

    // behavioural reference state
    bit       m_arm = 0;
    bit [3:0] m_base = 0;
    bit       m_clr = 0;
    bit [3:0] m_rise = 0;
    bit [3:0] m_fall = 0;
    bit [3:0] m_prev = 0;

    function automatic bit quiet(int i);
        return quiet_mask && (i == 0 || i == 2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_arm = 0; m_base = 0; m_clr = 0; m_rise = 0; m_fall = 0;
        end else begin
            m_clr = m_arm && !lp_mode;
            if (lp_mode && !m_arm) m_base = comp_lvl;
            m_arm = lp_mode;
            if (m_clr) begin m_rise = 0; m_fall = 0; end
        end
    end

    always @(comp_lvl) begin
        for (int i = 0; i < 4; i++) begin
            if (comp_lvl[i] !== m_prev[i] && m_arm && !quiet(i)) begin
                if (comp_lvl[i] && rise_en[i]) m_rise[i] = 1;
                if (!comp_lvl[i] && fall_en[i]) m_fall[i] = 1;
            end
        end
        m_prev = comp_lvl;
    end

    function automatic bit model_flag();
        bit f = 0;
        for (int i = 0; i < 4; i++) begin
            if (m_rise[i] || m_fall[i]) f = 1;
            if (m_arm && !quiet(i)) begin
                if (comp_lvl[i] && !m_base[i] && rise_en[i]) f = 1;
                if (!comp_lvl[i] && m_base[i] && fall_en[i]) f = 1;
            end
        end
        return f;
    endfunction

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(data_oe === lp_mode, "R1 drive enable", {7'b0, data_oe}, {7'b0, lp_mode});
        chk(irq_clr === m_clr, "R9 clear pulse", {7'b0, irq_clr}, {7'b0, m_clr});
        if (!lp_mode) begin
            chk(data_out === 8'h00, "R1 released bus", data_out, 8'h00);
        end else begin
            chk(data_out[1:0] === line_st, "R2 line state", {6'b0, data_out[1:0]}, {6'b0, line_st});
            chk({data_out[7:4], data_out[2]} === 5'b0, "R3 low bits", data_out, 8'h00);
            chk(data_out[3] === model_flag(), "R4 R5 R6 R7 R8 flag",
                {7'b0, data_out[3]}, {7'b0, model_flag()});
        end
    endtask

    always @(negedge clk) if (live) compare();

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_comp(logic [3:0] v);
        #1 comp_lvl = v;
    endtask

    task automatic leave_lp();
        lp_mode = 0;
        cyc(5);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        #1 live = 1;
        cyc(1);
        rst = 0;
        cyc(2);
        // R1 R2: line state outside and inside low power
        line_st = 2'b10; cyc(2);
        lp_mode = 1; cyc(1);
        line_st = 2'b01; #1 compare();
        cyc(2);
        leave_lp();
        // R5: session valid rise enabled
        rise_en = 4'b0010;
        lp_mode = 1; cyc(2);
        set_comp(4'b0010); cyc(3);
        leave_lp();
        // R5: ID ground, fall only
        rise_en = 4'b0000; fall_en = 4'b1000;
        lp_mode = 1; cyc(2);
        set_comp(4'b1010); cyc(2);
        set_comp(4'b0010); cyc(3);
        leave_lp();
        // R7: rise then fall with only rise enabled
        rise_en = 4'b0010; fall_en = 4'b0000; set_comp(4'b0000); cyc(1);
        lp_mode = 1; cyc(2);
        set_comp(4'b0010); cyc(1);
        set_comp(4'b0000); cyc(3);
        leave_lp();
        // R6: quiet mask on VBUS valid and session end
        rise_en = 4'b1111; fall_en = 4'b1111; quiet_mask = 1;
        lp_mode = 1; cyc(2);
        set_comp(4'b0101); cyc(2);
        set_comp(4'b0000); cyc(2);
        set_comp(4'b0010); cyc(2);
        leave_lp();
        quiet_mask = 0;
        // R8: level already high at entry, no false flag
        set_comp(4'b0101); cyc(2);
        lp_mode = 1; cyc(3);
        set_comp(4'b0001); cyc(2);
        leave_lp();
        // R8: change between lp_mode rise and first edge becomes baseline
        set_comp(4'b0000); cyc(1);
        lp_mode = 1; set_comp(4'b1000); cyc(3);
        leave_lp();
        // R7: clock halted during low power
        set_comp(4'b0000); cyc(1);
        lp_mode = 1; cyc(2);
        run = 0; #20;
        compare();
        comp_lvl = 4'b0100; #3 compare();
        comp_lvl = 4'b0000; #3 compare();
        line_st = 2'b11; #1 compare();
        #10 run = 1;
        cyc(3);
        leave_lp();
        // R10: reset mid low power
        lp_mode = 1; cyc(2);
        set_comp(4'b0010); cyc(1);
        rst = 1; lp_mode = 0; cyc(3);
        rst = 0; cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule